// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Limit Watchdog

This block merges eight interrupt sources, all of equal priority, into one active-high request line. Each source sets its own bit in a pending register. The request line is high whenever a pending bit is also enabled in the enable register. Software reads the pending register to learn which sources fired, and that read clears them. Because writing the enable register can raise false requests, software reads the pending register once after each enable write, which discards them.

The block generates three of its sources itself:

- **Limit watchdog.** For each watchdog step, the sequencer supplies a sample together with a limit selector. The sample is compared against one of two programmable limits. A sense bit stored with each limit chooses whether "above" or "below" counts as a crossing. A crossing raises source 0. A separate limit-status register records which limit tripped and the instruction pointer in force at that moment.
- **Instruction-pointer match.** Source 1 fires when the sequencer starts an instruction whose pointer equals a 3-bit field of the enable register. The flag is raised as the instruction starts, before it executes.
- **FIFO fill level.** Source 2 fires when the FIFO entry count reaches a programmable threshold.

The five remaining sources arrive as single-cycle pulses. Registers are reached through a simple strobed read/write bus whose read data is combinational.

Top module: `intr_gather`

## Requirements
- R1: After reset, the enable, pending and limit-status registers read as zero and `irq_o` is low.
- R2: `irq_o` is high exactly when some pending bit is set whose matching enable bit (enable register bits 7:0, address 0) is also set. A pending source that is masked leaves `irq_o` low.
- R3: A read of address 1 returns the pending bits in bits 7:0 and clears them with that same access. A second read returns zero.
- R4: A source event that arrives in the same cycle as a pending-register read stays pending after that read.
- R5: A one-cycle pulse on `ext_evt_i[k]` sets pending bit k+3.
- R6: A `wd_valid_i` strobe compares `wd_sample_i` with limit A (address 2) when `wd_sel_i` is 0, or with limit B (address 3) when `wd_sel_i` is 1. In each limit register, bits 11:0 hold the unsigned value and bit 12 is the sense bit. With sense 1 the comparison trips when the sample is above the limit; with sense 0 it trips when the sample is below it. An equal sample never trips. A trip sets pending bit 0.
- R7: The limit-status register (address 4) reports the trip in bit 0 (limit A) or bit 1 (limit B), and `instr_ptr_i` at the time of the trip in bits 4:2. Reading it clears it.
- R8: An `instr_start_i` strobe whose `instr_ptr_i` equals enable bits 10:8 sets pending bit 1 at the clock edge that samples the strobe. A pointer that does not match, or a matching pointer without the strobe, sets nothing.
- R9: Pending bit 2 is set once, in the cycle when `fifo_cnt_i` becomes equal to enable bits 15:11. While the count stays equal, the bit is not set again.
- R10: The enable register and both limit registers read back exactly the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (clears the pending and limit-status registers) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| ext_evt_i | input | 5 | Pulse sources 3 to 7 |
| instr_start_i | input | 1 | Sequencer is starting the instruction at `instr_ptr_i` |
| instr_ptr_i | input | 3 | Current instruction pointer |
| fifo_cnt_i | input | 5 | FIFO entry count |
| wd_valid_i | input | 1 | Watchdog comparison strobe |
| wd_sel_i | input | 1 | Limit selector for the comparison (0 = A, 1 = B) |
| wd_sample_i | input | 12 | Sample under comparison |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight sources, a 3-bit instruction pointer, a 5-bit FIFO count and 12-bit limits. With these values the enable register fills all 16 bus bits, so the pointer field and the threshold field can both be written and read back at their stated positions. The 12-bit limits allow comparisons just above, just below and exactly at a limit for both sense settings. The 5-bit count lets a threshold be approached, held and re-approached, which checks that the FIFO source fires only once per arrival.

// File: rtl/intr_gather_pkg.sv
package intr_gather_pkg;
  localparam logic [2:0] A_EN    = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_LIMA  = 3'd2;
  localparam logic [2:0] A_LIMB  = 3'd3;
  localparam logic [2:0] A_LSTAT = 3'd4;

  localparam int SRC_WD   = 0;
  localparam int SRC_PTR  = 1;
  localparam int SRC_FIFO = 2;
  localparam int SRC_EXT0 = 3;
endpackage

// File: rtl/pend_reg.sv
module pend_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= (q_o[i] & ~clr_i) | set_i[i];
    end

    AST_SET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]); // R4
  end

  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> q_o == '0); // R3
endmodule

// File: rtl/wd_compare.sv
module wd_compare #(
  parameter int LIM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sel_i,
  input  logic [LIM_W-1:0] sample_i,
  input  logic [LIM_W:0]   lim_a_i,
  input  logic [LIM_W:0]   lim_b_i,
  output logic             trip_o
);
  logic [LIM_W:0] lim;
  logic           above, below;

  always_comb begin
    lim    = sel_i ? lim_b_i : lim_a_i;
    above  = sample_i > lim[LIM_W-1:0];
    below  = sample_i < lim[LIM_W-1:0];
    // bit LIM_W is the sense: 1 trips above, 0 trips below
    trip_o = valid_i && (lim[LIM_W] ? above : below);
  end

  AST_EQ_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sel_i && sample_i == lim_a_i[LIM_W-1:0]) |-> !trip_o); // R6
  AST_IDLE_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !trip_o); // R6
endmodule

// File: rtl/evt_detect.sv
module evt_detect #(
  parameter int PTR_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_start_i,
  input  logic [PTR_W-1:0] instr_ptr_i,
  input  logic [PTR_W-1:0] ptr_match_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [CNT_W-1:0] fifo_thr_i,
  output logic             ptr_hit_o,
  output logic             fifo_hit_o
);
  logic eq, eq_q;

  assign eq         = fifo_cnt_i == fifo_thr_i;
  assign fifo_hit_o = eq & ~eq_q;
  assign ptr_hit_o  = instr_start_i && (instr_ptr_i == ptr_match_i);

  // start as "already equal" so a count of 0 at reset does not fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b1;
    else         eq_q <= eq;
  end

  AST_FIFO_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_hit_o |=> !fifo_hit_o); // R9
  AST_PTR_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_hit_o |-> instr_start_i); // R8
endmodule

// File: rtl/intr_gather.sv
module intr_gather
  import intr_gather_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 5,
  parameter int LIM_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-4:0]  ext_evt_i,
  input  logic              instr_start_i,
  input  logic [PTR_W-1:0]  instr_ptr_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic              wd_valid_i,
  input  logic              wd_sel_i,
  input  logic [LIM_W-1:0]  wd_sample_i,
  output logic              irq_o
);
  localparam int PTR_LSB = N_SRC;
  localparam int THR_LSB = N_SRC + PTR_W;
  localparam int EN_W    = THR_LSB + CNT_W;

  logic [EN_W-1:0]  en_q;
  logic [LIM_W:0]   lim_a_q, lim_b_q;
  logic [N_SRC-1:0] new_evt, pend_q;
  logic [1:0]       lhit_set, lhit_q;
  logic [PTR_W-1:0] lptr_q;
  logic             trip, ptr_hit, fifo_hit;
  logic             stat_clr, lstat_clr;

  assign stat_clr  = rd_i && addr_i == A_STAT;
  assign lstat_clr = rd_i && addr_i == A_LSTAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      lim_a_q <= '0;
      lim_b_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_EN)   en_q    <= wdata_i[EN_W-1:0];
      if (addr_i == A_LIMA) lim_a_q <= wdata_i[LIM_W:0];
      if (addr_i == A_LIMB) lim_b_q <= wdata_i[LIM_W:0];
    end
  end

  wd_compare #(.LIM_W(LIM_W)) u_wd (
    .clk_i, .rst_ni,
    .valid_i(wd_valid_i), .sel_i(wd_sel_i), .sample_i(wd_sample_i),
    .lim_a_i(lim_a_q), .lim_b_i(lim_b_q), .trip_o(trip)
  );

  evt_detect #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_evt (
    .clk_i, .rst_ni,
    .instr_start_i, .instr_ptr_i,
    .ptr_match_i(en_q[PTR_LSB +: PTR_W]),
    .fifo_cnt_i, .fifo_thr_i(en_q[THR_LSB +: CNT_W]),
    .ptr_hit_o(ptr_hit), .fifo_hit_o(fifo_hit)
  );

  always_comb begin
    new_evt                 = '0;
    new_evt[SRC_WD]         = trip;
    new_evt[SRC_PTR]        = ptr_hit;
    new_evt[SRC_FIFO]       = fifo_hit;
    new_evt[N_SRC-1:SRC_EXT0] = ext_evt_i;
  end

  pend_reg #(.W(N_SRC)) u_pend (
    .clk_i, .rst_ni, .set_i(new_evt), .clr_i(stat_clr), .q_o(pend_q)
  );

  assign lhit_set = {trip & wd_sel_i, trip & ~wd_sel_i};

  pend_reg #(.W(2)) u_lhit (
    .clk_i, .rst_ni, .set_i(lhit_set), .clr_i(lstat_clr), .q_o(lhit_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lptr_q <= '0;
    else if (trip)      lptr_q <= instr_ptr_i;
    else if (lstat_clr) lptr_q <= '0;
  end

  assign irq_o = |(pend_q & en_q[N_SRC-1:0]);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EN:    rdata_o[EN_W-1:0]  = en_q;
      A_STAT:  rdata_o[N_SRC-1:0] = pend_q;
      A_LIMA:  rdata_o[LIM_W:0]   = lim_a_q;
      A_LIMB:  rdata_o[LIM_W:0]   = lim_b_q;
      A_LSTAT: begin
        rdata_o[1:0]       = lhit_q;
        rdata_o[2 +: PTR_W] = lptr_q;
      end
      default: rdata_o = '0;
    endcase
  end

  AST_IRQ_DROPS_ON_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && new_evt == '0) |=> !irq_o); // R3
  AST_TRIP_LOGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |=> (lhit_q[$past(wd_sel_i)] && lptr_q == $past(instr_ptr_i))); // R7
  AST_TRIP_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |=> pend_q[SRC_WD]); // R6
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[N_SRC-1:0] == '0) |-> !irq_o); // R2
endmodule

// File: tb/intr_gather_bench.sv
module intr_gather_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [4:0]  ext = '0;
  logic        istart = 1'b0;
  logic [2:0]  iptr = '0;
  logic [4:0]  fcnt = '0;
  logic        wdv = 1'b0, wds = 1'b0;
  logic [11:0] wsamp = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  intr_gather u_intr_gather (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_evt_i(ext),
    .instr_start_i(istart), .instr_ptr_i(iptr), .fifo_cnt_i(fcnt),
    .wd_valid_i(wdv), .wd_sel_i(wds), .wd_sample_i(wsamp), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    tick();
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq", {15'd0, irq}, 16'h0);
    rd_reg(3'd0, d); check("R1 enable", d, 16'h0);
    rd_reg(3'd1, d); check("R1 pending", d, 16'h0);
    rd_reg(3'd4, d); check("R1 limit status", d, 16'h0);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    ext = 5'b00001; tick(); ext = '0;
    check("R2 masked no irq", {15'd0, irq}, 16'h0);
    rd_reg(3'd1, d); check("R5 ext0 -> bit3", d, 16'h0008);
    rd_reg(3'd1, d); check("R3 cleared", d, 16'h0);
    wr_reg(3'd0, 16'h0080);
    rd_reg(3'd0, d); check("R10 enable readback", d, 16'h0080);
    rd_reg(3'd1, d);
    ext = 5'b10000; tick(); ext = '0;
    check("R2 enabled irq", {15'd0, irq}, 16'h1);
    rd_reg(3'd1, d); check("R5 ext4 -> bit7", d, 16'h0080);
    check("R3 irq drops after read", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    wr_reg(3'd0, 16'h0010);
    rd_reg(3'd1, d);
    ext = 5'b00010; rd = 1'b1; addr = 3'd1;
    #1 d = rdata;
    tick();
    rd = 1'b0; ext = '0;
    check("R4 read value before event", d, 16'h0);
    check("R4 irq kept", {15'd0, irq}, 16'h1);
    rd_reg(3'd1, d); check("R4 event kept", d, 16'h0010);
  endtask

  task automatic t_wd();
    logic [15:0] d;
    wr_reg(3'd0, 16'h0001);
    wr_reg(3'd2, 16'h1064);   // sense above, 100
    wr_reg(3'd3, 16'h0032);   // sense below, 50
    rd_reg(3'd2, d); check("R10 limit A readback", d, 16'h1064);
    rd_reg(3'd3, d); check("R10 limit B readback", d, 16'h0032);
    rd_reg(3'd1, d);
    iptr = 3'd5; wdv = 1'b1; wds = 1'b0; wsamp = 12'd100; tick();
    wdv = 1'b0;
    check("R6 equal no trip", {15'd0, irq}, 16'h0);
    wdv = 1'b1; wsamp = 12'd101; tick(); wdv = 1'b0;
    check("R6 above trips", {15'd0, irq}, 16'h1);
    rd_reg(3'd4, d); check("R7 limit A + ptr", d, 16'h0015);
    rd_reg(3'd4, d); check("R7 cleared", d, 16'h0);
    rd_reg(3'd1, d); check("R6 pending bit0", d, 16'h0001);
    iptr = 3'd2; wdv = 1'b1; wds = 1'b1; wsamp = 12'd60; tick();
    wdv = 1'b0;
    check("R6 below-sense ignores above", {15'd0, irq}, 16'h0);
    wdv = 1'b1; wsamp = 12'd49; tick(); wdv = 1'b0; wds = 1'b0;
    check("R6 below trips", {15'd0, irq}, 16'h1);
    rd_reg(3'd4, d); check("R7 limit B + ptr", d, 16'h000A);
    rd_reg(3'd1, d);
  endtask

  task automatic t_ptr();
    logic [15:0] d;
    wr_reg(3'd0, 16'h0602);
    rd_reg(3'd1, d);
    iptr = 3'd6; tick();
    check("R8 no start no hit", {15'd0, irq}, 16'h0);
    iptr = 3'd3; istart = 1'b1; tick(); istart = 1'b0;
    check("R8 mismatch no hit", {15'd0, irq}, 16'h0);
    iptr = 3'd6; istart = 1'b1; tick(); istart = 1'b0;
    check("R8 match hit", {15'd0, irq}, 16'h1);
    rd_reg(3'd1, d); check("R8 pending bit1", d, 16'h0002);
  endtask

  task automatic t_fifo();
    logic [15:0] d;
    wr_reg(3'd0, 16'h4804);   // threshold 9, enable bit2
    rd_reg(3'd1, d);
    fcnt = 5'd9; tick(); tick(); tick();
    check("R9 reach fires", {15'd0, irq}, 16'h1);
    rd_reg(3'd1, d); check("R9 pending bit2", d, 16'h0004);
    tick(); tick();
    rd_reg(3'd1, d); check("R9 no refire while equal", d, 16'h0);
    fcnt = 5'd8; tick();
    fcnt = 5'd9; tick();
    rd_reg(3'd1, d); check("R9 refire on re-arrival", d, 16'h0004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_ext();
    t_same_cycle();
    t_wd();
    t_ptr();
    t_fifo();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule